// File: doc/BRIEF.md
# Byte-wide SPI master with host registers

This block connects a host register port to a four-wire serial peripheral link and acts as the link master. The host sets a control byte that selects the clock polarity, the clock phase, the bit order and one of eight SCK rates. A write to the data register then starts one full-duplex 8-bit exchange. The block generates SCK, drives the outgoing bits on MOSI and samples MISO on the opposite clock edge. It holds the slave select low for the whole byte.

When the byte is finished, the incoming bits are copied into a one-byte receive buffer and a completion flag is raised. No transmit buffer exists: the data register write goes straight into the shifter. A second write while a byte is on the wire is refused and is recorded as a collision. Both flags are cleared by a status read followed by a data-register access, and an enable bit passes either flag to an interrupt line.

The host port is synchronous. A write takes effect on the clock edge where `wr_en` is high. Read data appears on `rdata` one cycle after the `rd_en` cycle.

Top module: `spi_host_ctrl`

## Requirements
- R1: Register addresses are 0 = control, 1 = status, 2 = data. Control bits from 7 down to 0 are: interrupt enable, SPI enable, LSB-first, master, CPOL, CPHA, rate 1, rate 0. The control register resets to 0x00 and reads back what was written. Status reads as {done flag, collision flag, 5'b0, double-speed}. Only the double-speed bit is writable. After reset, ss_n is 1 and sck, irq and mosi are 0.
- R2: The SCK period, in clocks, is selected by {double-speed, rate1, rate0}. Codes 0 to 3 give 4, 16, 64 and 128. Codes 4 to 7 give 2, 8, 32 and 64. A byte keeps ss_n low for 8 SCK periods.
- R3: A data write while enable=1, master=1 and the block is idle starts a byte on the next edge. ss_n is low for the byte and high between bytes.
- R4: SCK idles at CPOL and makes 16 edges per byte. With CPHA=0, MISO is sampled on the odd-numbered edges (1st, 3rd, ...). With CPHA=1, MISO is sampled on the even-numbered edges.
- R5: With LSB-first=0 bit 7 goes out first; with LSB-first=1 bit 0 goes out first. With CPHA=0 the first bit is on MOSI in the cycle after the starting write, before any SCK edge.
- R6: At the end of a byte, the received byte is copied into the receive buffer. A data read returns that buffer.
- R7: The done flag is set one cycle after the byte ends. It is cleared only by a status read made while a flag is set, followed by a data-register read or write. A data access without the preceding status read leaves it set.
- R8: A data write during a byte sets the collision flag and leaves the byte on MOSI and the received byte unchanged. The same status-then-data sequence clears it.
- R9: irq is 1 exactly when interrupt enable is set and the done flag or the collision flag is set.
- R10: Clearing SPI enable during a byte aborts it. SCK returns to CPOL, ss_n goes high and the done flag is not set.
- R11: A data write with enable=0 or master=0 starts nothing: ss_n stays high and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench aims at the flag-clearing order. A design that cleared the flags on any data access would lose the done flag when the buffer is read first, and a design that never armed the clear would leave irq stuck. A write made in the middle of a byte must set the collision flag and leave the shifted byte intact; a design that reloaded the shifter would return a corrupted byte to the slave model. All eight rate codes are run across the four clock modes and both bit orders, and SCK is compared to the model on every clock. A wrong divider entry, a missing first bit under CPHA=0 or a wrong sampling edge therefore shows up as a timing or data mismatch. An abort by clearing enable must leave SCK at its idle level with no done flag, and writes made while disabled or not in master mode must leave ss_n high.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  // bit layout is host visible, MSB first
  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // half of the SCK period in system clocks
  function automatic int unsigned half_period(input logic dbl, input logic [1:0] rate);
    int unsigned sh;
    case (rate)
      2'd0:    sh = 2;
      2'd1:    sh = 4;
      2'd2:    sh = 6;
      default: sh = 7;
    endcase
    if (dbl) sh = sh - 1;
    return 32'd1 << (sh - 1);
  endfunction
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] half,
  output logic          tick
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == half - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R2: consecutive ticks only for the fastest rate
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && half != CW'(1) && !restart) |=> (!tick || half == CW'(1)));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          start,
  input  logic [DW-1:0] load,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          ss_n,
  output logic          done,
  output logic [DW-1:0] rx
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NEDGE = 2 * DW;
  localparam int EW    = $clog2(NEDGE);
  localparam logic [EW-1:0] LAST = EW'(NEDGE - 1);

  logic [EW-1:0] edge_n;
  logic [DW-1:0] tx;

  function automatic logic head(input logic [DW-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DW-1];
  endfunction

  function automatic logic [DW-1:0] advance(input logic [DW-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  function automatic logic [DW-1:0] take(input logic [DW-1:0] r, input logic b, input logic lsb);
    return lsb ? {b, r[DW-1:1]} : {r[DW-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      ss_n   <= 1'b1;
      done   <= 1'b0;
      edge_n <= '0;
      tx     <= '0;
      rx     <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
        sck  <= cpol;
        ss_n <= 1'b1;
      end else if (start) begin
        busy   <= 1'b1;
        ss_n   <= 1'b0;
        sck    <= cpol;
        edge_n <= '0;
        if (!cpha) begin
          mosi <= head(load, lsb_first);
          tx   <= advance(load, lsb_first);
        end else begin
          tx   <= load;
        end
      end else if (busy) begin
        if (tick) begin
          sck    <= ~sck;
          edge_n <= edge_n + EW'(1);
          if (edge_n[0] == cpha) begin
            rx <= take(rx, miso, lsb_first);
          end else if (cpha || edge_n != LAST) begin
            mosi <= head(tx, lsb_first);
            tx   <= advance(tx, lsb_first);
          end
          if (edge_n == LAST) begin
            busy <= 1'b0;
            ss_n <= 1'b1;
            done <= 1'b1;
          end
        end
      end else begin
        sck <= cpol;
      end
    end
  end

  // R7: a completion only follows an active byte
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  // R4: an idle SCK sits at the polarity level
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sck == $past(cpol)));
  // R2: SCK moves only on a divider tick
  p_sck_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && en && !start) |=> $stable(sck));
  // R10: disabling drops the select
  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> ss_n);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx,
  output ctrl_t         ctrl,
  output logic          dbl,
  output logic          start
);
  timeunit 1ns;
  timeprecision 1ps;

  ctrl_t         ctrl_n;
  logic          dbl_n, spif_q, spif_n, wcol_q, wcol_n, arm_q, arm_n;
  logic [DW-1:0] rxbuf;
  logic          data_acc, data_wr;

  assign data_acc = (wr_en || rd_en) && addr == ADR_DATA;
  assign data_wr  = wr_en && addr == ADR_DATA;
  assign start    = data_wr && !busy && ctrl.enable && ctrl.master;

  always_comb begin
    ctrl_n = ctrl;
    dbl_n  = dbl;
    spif_n = spif_q;
    wcol_n = wcol_q;
    arm_n  = arm_q;
    if (data_acc && arm_q) begin
      spif_n = 1'b0;
      wcol_n = 1'b0;
      arm_n  = 1'b0;
    end else if (rd_en && addr == ADR_STAT && (spif_q || wcol_q)) begin
      arm_n = 1'b1;
    end
    if (done) spif_n = 1'b1;
    if (data_wr && busy) wcol_n = 1'b1;
    if (wr_en && addr == ADR_CTRL) ctrl_n = ctrl_t'(wdata[7:0]);
    if (wr_en && addr == ADR_STAT) dbl_n = wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      dbl    <= 1'b0;
      spif_q <= 1'b0;
      wcol_q <= 1'b0;
      arm_q  <= 1'b0;
      irq    <= 1'b0;
      rxbuf  <= '0;
      rdata  <= '0;
    end else begin
      ctrl   <= ctrl_n;
      dbl    <= dbl_n;
      spif_q <= spif_n;
      wcol_q <= wcol_n;
      arm_q  <= arm_n;
      irq    <= ctrl_n.irq_en && (spif_n || wcol_n);
      if (done) rxbuf <= rx;
      if (rd_en) begin
        case (addr)
          ADR_CTRL: rdata <= DW'(ctrl);
          ADR_STAT: rdata <= DW'({spif_q, wcol_q, 5'b00000, dbl});
          ADR_DATA: rdata <= rxbuf;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  // R8: a write during a byte flags a collision
  p_wcol_set_r8: assert property (@(posedge clk) disable iff (rst)
    (data_wr && busy) |=> wcol_q);
  // R7: completion sets the done flag
  p_spif_set_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> spif_q);
  // R9: no interrupt without the enable bit
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl.irq_en);
  // R6: the receive buffer only changes on completion
  p_rxbuf_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(rxbuf));
  // R7: a data access without arming leaves the done flag set
  p_no_clear_unarmed_r7: assert property (@(posedge clk) disable iff (rst)
    (spif_q && !arm_q) |=> spif_q);
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  timeunit 1ns;
  timeprecision 1ps;

  ctrl_t              ctrl;
  logic               dbl, start, busy, done, tick;
  logic [DATA_W-1:0]  rx;
  logic [DIV_W-1:0]   half;

  assign half = DIV_W'(half_period(dbl, ctrl.rate));

  spi_host_regs #(.DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .busy(busy), .done(done),
    .rx(rx), .ctrl(ctrl), .dbl(dbl), .start(start)
  );

  spi_rate_div #(.CW(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .restart(start), .half(half), .tick(tick)
  );

  spi_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .en(ctrl.enable), .cpol(ctrl.cpol), .cpha(ctrl.cpha),
    .lsb_first(ctrl.lsb_first), .start(start), .load(wdata), .tick(tick),
    .miso(miso), .busy(busy), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .done(done), .rx(rx)
  );

  // R3: the select is only low after a start
  p_ss_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ss_n) |-> $past(start));
endmodule

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, miso = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq, sck, mosi, ss_n;

  always #2.5 clk = ~clk;

  spi_host_ctrl u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  logic [7:0] m_ctrl, cap_mosi, sbyte = 8'h00;
  logic m_dbl, m_spif, m_wcol, m_arm, m_irq, m_busy, m_sck, m_ss, m_pend;
  logic done_now, old_busy;
  int m_cnt, m_edge, m_nsamp;

  function automatic int half_of(input logic [7:0] c, input logic d);
    case ({d, c[1:0]})
      3'd0: return 2;  3'd1: return 8;  3'd2: return 32; 3'd3: return 64;
      3'd4: return 1;  3'd5: return 4;  3'd6: return 16; default: return 32;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_dbl = 0; m_spif = 0; m_wcol = 0; m_arm = 0; m_irq = 0;
      m_busy = 0; m_sck = 0; m_ss = 1; m_pend = 0; m_nsamp = 0; cap_mosi = 0;
    end else begin
      done_now = 0;
      old_busy = m_busy;
      if (!m_ctrl[6]) begin
        m_busy = 0; m_sck = m_ctrl[3]; m_ss = 1;
      end else if (wr_en && addr == AD && !m_busy && m_ctrl[4]) begin
        m_busy = 1; m_cnt = 0; m_edge = 0; m_sck = m_ctrl[3]; m_ss = 0;
        m_nsamp = 0; cap_mosi = 0;
      end else if (m_busy) begin
        if (m_cnt == half_of(m_ctrl, m_dbl) - 1) begin
          if ((m_edge & 1) == int'(m_ctrl[2])) begin
            if (m_ctrl[5]) cap_mosi[m_nsamp] = mosi;
            else cap_mosi[7 - m_nsamp] = mosi;
            m_nsamp++;
          end
          m_sck = !m_sck; m_cnt = 0;
          if (m_edge == 15) begin m_busy = 0; m_ss = 1; done_now = 1; end
          m_edge++;
        end else m_cnt++;
      end else m_sck = m_ctrl[3];
      if (m_arm && (wr_en || rd_en) && addr == AD) begin
        m_spif = 0; m_wcol = 0; m_arm = 0;
      end else if (rd_en && addr == AS && (m_spif || m_wcol)) m_arm = 1;
      if (m_pend) m_spif = 1;
      if (wr_en && addr == AD && old_busy) m_wcol = 1;
      m_pend = done_now;
      if (wr_en && addr == AC) m_ctrl = wdata;
      if (wr_en && addr == AS) m_dbl = wdata[0];
      m_irq = m_ctrl[7] && (m_spif || m_wcol);
    end
  end

  // slave model drives the next expected bit
  always @(negedge clk) begin
    if (m_nsamp < 8) miso <= m_ctrl[5] ? sbyte[m_nsamp] : sbyte[7 - m_nsamp];
    else miso <= 1'b0;
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(sck == m_sck, "R4 sck vs model", sck, m_sck);
      chk(ss_n == m_ss, "R3 ss_n vs model", ss_n, m_ss);
      chk(irq == m_irq, "R9 irq vs model", irq, m_irq);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (ss_n == 1'b0) @(negedge clk);
    waitn(2);
  endtask

  task automatic xfer(input logic [7:0] ctl, input logic dbl, input logic [7:0] tx,
                      input logic [7:0] sb);
    logic [7:0] v;
    int lows, hp;
    sbyte = sb;
    hp = half_of(ctl, dbl);
    wr(AS, {7'b0, dbl});
    wr(AC, ctl);
    wr(AD, tx);
    if (!ctl[2])
      chk(mosi == (ctl[5] ? tx[0] : tx[7]), "R5 first bit before SCK", mosi, ctl[5] ? tx[0] : tx[7]);
    lows = 0;
    while (ss_n == 1'b0) begin lows++; @(negedge clk); end
    chk(lows == 16 * hp, "R2 byte length", lows, 16 * hp);
    chk(cap_mosi == tx, "R5 byte seen by slave", cap_mosi, tx);
    rd(AS, v);
    chk(v == {1'b1, 6'b0, dbl}, "R7 done flag set", v, {1'b1, 6'b0, dbl});
    rd(AD, v);
    chk(v == sb, "R6 received byte", v, sb);
    rd(AS, v);
    chk(v == {7'b0, dbl}, "R7 done flag cleared", v, {7'b0, dbl});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int lows;
    waitn(4);
    rst = 1'b0;
    waitn(1);
    // R1 reset state and register access
    chk(ss_n == 1 && sck == 0 && irq == 0 && mosi == 0, "R1 reset outputs",
        {ss_n, sck, irq, mosi}, 4'b1000);
    rd(AC, v); chk(v == 8'h00, "R1 control reset", v, 8'h00);
    rd(AS, v); chk(v == 8'h00, "R1 status reset", v, 8'h00);
    wr(AC, 8'hA5);
    rd(AC, v); chk(v == 8'hA5, "R1 control readback", v, 8'hA5);
    wr(AC, 8'h00);
    wr(AS, 8'hFF);
    rd(AS, v); chk(v == 8'h01, "R1 status write mask", v, 8'h01);
    wr(AS, 8'h00);

    // R2 R4 R5 all rates, modes and orders
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ctl;
      ctl = 8'h50 | 8'((i % 4) << 2) | ((i % 3 == 1) ? 8'h20 : 8'h00) | 8'(i & 3);
      xfer(ctl, 1'(i >> 2), 8'h96 ^ 8'(i * 37), 8'h5A + 8'(i * 19));
    end
    xfer(8'h7C, 1'b0, 8'h81, 8'h7E);

    // R7 data read first does not clear
    sbyte = 8'hC3;
    wr(AD, 8'h42);
    wait_idle();
    rd(AD, v); chk(v == 8'hC3, "R6 buffer after byte", v, 8'hC3);
    rd(AS, v); chk(v == 8'h80, "R7 unarmed access keeps flag", v, 8'h80);
    rd(AD, v);
    rd(AS, v); chk(v == 8'h00, "R7 armed clear", v, 8'h00);

    // R8 collision
    wr(AC, 8'h50);
    sbyte = 8'h3C;
    wr(AD, 8'hA5);
    waitn(10);
    wr(AD, 8'h00);
    wait_idle();
    chk(cap_mosi == 8'hA5, "R8 byte undisturbed", cap_mosi, 8'hA5);
    rd(AS, v); chk(v == 8'hC0, "R8 collision flag", v, 8'hC0);
    rd(AD, v); chk(v == 8'h3C, "R8 received byte intact", v, 8'h3C);
    rd(AS, v); chk(v == 8'h00, "R8 collision cleared", v, 8'h00);

    // R9 interrupt
    wr(AC, 8'hD0);
    wr(AD, 8'h11);
    wait_idle();
    chk(irq == 1'b1, "R9 irq on done", irq, 1);
    rd(AS, v); rd(AD, v);
    waitn(1);
    chk(irq == 1'b0, "R9 irq after clear", irq, 0);
    wr(AC, 8'h50);
    wr(AD, 8'h22);
    wait_idle();
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    rd(AS, v); rd(AD, v);

    // R10 abort
    wr(AC, 8'h59);
    wr(AD, 8'hF0);
    waitn(20);
    wr(AC, 8'h19);
    waitn(2);
    chk(ss_n == 1'b1, "R10 select released", ss_n, 1);
    chk(sck == 1'b1, "R10 sck idle", sck, 1);
    waitn(300);
    rd(AS, v); chk(v == 8'h00, "R10 no done flag", v, 8'h00);

    // R11 no start when disabled or not master
    wr(AC, 8'h40);
    wr(AD, 8'h55);
    lows = 0;
    for (int k = 0; k < 40; k++) begin if (!ss_n) lows++; @(negedge clk); end
    chk(lows == 0, "R11 not master", lows, 0);
    wr(AC, 8'h10);
    wr(AD, 8'h55);
    lows = 0;
    for (int k = 0; k < 40; k++) begin if (!ss_n) lows++; @(negedge clk); end
    chk(lows == 0, "R11 disabled", lows, 0);
    rd(AS, v); chk(v == 8'h00, "R11 no flags", v, 8'h00);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule